// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block decodes a small I/O window that carries the bus-master DMA control registers of a two-channel disk controller. Each channel owns an 8-byte slice of the window. The lower half of a slice is a byte-only command/status area. The upper half is a 32-bit descriptor-table pointer. The host reaches the window over a plain I/O port bus: an address, a size code, read and write strobes, write data and combinational read data.

The command byte is stored whole. Its start bit and its direction bit are driven out to the DMA engine. The status byte has two event flags: error and interrupt. The engine sets these with one-cycle pulses, and software clears them by writing ones. The status byte also has two plain read/write capability bits, one for each drive. The pointer outputs feed the engine directly.

Host data is right-aligned on both data buses. Size code 0 is one byte, code 1 is two bytes, and codes 2 and 3 are four bytes. The host never asserts read and write in the same cycle. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `busmaster_regwin`

## Requirements
- R1: Address bit 3 selects the channel (0 or 1). Address bit 2 selects that channel's command/status area (0) or its pointer (1). An access never touches the registers of the other channel or of the other area.
- R2: In the command/status area, a one-byte read with address bits [1:0] = 0 returns the command byte and one with bits [1:0] = 2 returns the status byte. A one-byte read at bits [1:0] = 1 or 3 returns 0xFF, and a one-byte write there changes nothing.
- R3: A read in the command/status area with a size other than one byte returns ones across the access width: 0x0000FFFF for two bytes and 0xFFFFFFFF for four bytes.
- R4: A write in the command/status area with a size other than one byte changes no register.
- R5: A one-byte write to the command offset stores all 8 bits. The start output is bit 0 of the stored byte and the direction output is bit 3.
- R6: Status bit 1 (error) and bit 2 (interrupt) are set by the channel's error and interrupt event inputs. Writing a 1 to one of these bits clears it, and writing a 0 leaves it alone. If a set and a clear arrive in the same cycle, the set wins.
- R7: Status bits 5 and 6 (drive-0 and drive-1 capability) take the written value. Status bits 0, 3, 4 and 7 always read 0.
- R8: The pointer accepts writes of one, two or four bytes. A one-byte access uses lane = address bits [1:0], a two-byte access uses lanes starting at 2*address bit 1, and a four-byte access uses all lanes. A read returns the pointer shifted right by 8 times that lane offset and masked to the access width.
- R9: Pointer bits [1:0] always read as zero.
- R10: Reset clears the command, status and pointer registers of both channels. Read data is 0 in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| io_addr | input | 4 | Byte address within the window |
| io_size | input | 2 | Access size: 0 byte, 1 two bytes, 2/3 four bytes |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data, right-aligned |
| io_rdata | output | 32 | Read data, right-aligned, combinational |
| ev_irq | input | 2 | Per-channel interrupt event pulse |
| ev_err | input | 2 | Per-channel error event pulse |
| dma_start | output | 2 | Per-channel start bit |
| dma_dir | output | 2 | Per-channel direction bit |
| dma_ptr | output | 64 | Per-channel pointer, channel 0 in bits [31:0] |

## Verification
The assertions take for granted that read and write are never asserted together. The one that checks ignored wide writes (R4) also assumes that the command register has no writer other than the host bus. The clear-side assertion of the interrupt flag only fires when no interrupt event arrives in the same cycle, so it assumes the event pulses are the only other source of a set. The random stimulus picks exactly one of read, write or idle each cycle and raises events independently of bus traffic. Directed cases then force a set and a clear into the same cycle.

// File: rtl/bmw_pkg.sv
package bmw_pkg;

  localparam int LANES   = 4;
  localparam int DATA_W  = 8 * LANES;

  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ERR    = 1;
  localparam int ST_IRQ    = 2;
  localparam int ST_CAP0   = 5;
  localparam int ST_CAP1   = 6;

  localparam logic [1:0] OFF_CMD = 2'd0;
  localparam logic [1:0] OFF_ST  = 2'd2;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORDX = 2'd3
  } io_size_e;

  // effective lane offset of an access
  function automatic logic [1:0] lane_off(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: lane_off = lo;
      SZ_HALF: lane_off = {lo[1], 1'b0};
      default: lane_off = 2'd0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    logic [1:0] off;
    off = lane_off(sz, lo);
    case (sz)
      SZ_BYTE: lane_mask = 4'b0001 << off;
      SZ_HALF: lane_mask = 4'b0011 << off;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/bmw_decode.sv
module bmw_decode
  import bmw_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [1:0]                size,
  input  logic                      wr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_CH-1:0]         cmd_we,
  output logic [NUM_CH-1:0]         st_we,
  output logic [NUM_CH*LANES-1:0]   ptr_be,
  output logic [DATA_W-1:0]         ptr_wdata
);

  localparam int CH_W = ADDR_W - 3;

  logic [CH_W-1:0]  ch_idx;
  logic             in_ptr;
  logic [1:0]       lo;
  logic             is_byte;
  logic [1:0]       off;
  logic [LANES-1:0] mask;
  logic [NUM_CH-1:0] ptr_any;

  always_comb begin
    ch_idx    = addr[ADDR_W-1:3];
    in_ptr    = addr[2];
    lo        = addr[1:0];
    is_byte   = (size == SZ_BYTE);
    off       = lane_off(size, lo);
    mask      = lane_mask(size, lo);
    ptr_wdata = wdata << {off, 3'b000};
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    logic hit;
    always_comb begin
      hit       = wr && (ch_idx == c[CH_W-1:0]);
      cmd_we[c] = hit && !in_ptr && is_byte && (lo == OFF_CMD);
      st_we[c]  = hit && !in_ptr && is_byte && (lo == OFF_ST);
      ptr_be[c*LANES +: LANES] = (hit && in_ptr) ? mask : '0;
      ptr_any[c] = |ptr_be[c*LANES +: LANES];
    end
  end

  // R1: at most one register target per access
  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we, st_we, ptr_any}));

  // R4: a wide access never strobes a command/status register
  assert_wide_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (size != SZ_BYTE) |-> (cmd_we == '0 && st_we == '0));

endmodule

// File: rtl/bmw_channel.sv
module bmw_channel
  import bmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              st_we,
  input  logic [LANES-1:0]  ptr_be,
  input  logic [7:0]        byte_wdata,
  input  logic [DATA_W-1:0] ptr_wdata,
  input  logic              ev_irq,
  input  logic              ev_err,
  output logic [7:0]        cmd_q,
  output logic [7:0]        st_q,
  output logic [DATA_W-1:0] ptr_q
);

  logic [7:0]        cmd_d;
  logic [7:0]        st_d;
  logic [DATA_W-1:0] ptr_d;
  logic              st_en;
  logic              ptr_en;

  always_comb begin
    cmd_d = byte_wdata;

    st_d = st_q;
    if (st_we) begin
      st_d[ST_CAP0] = byte_wdata[ST_CAP0];
      st_d[ST_CAP1] = byte_wdata[ST_CAP1];
      if (byte_wdata[ST_ERR]) st_d[ST_ERR] = 1'b0;
      if (byte_wdata[ST_IRQ]) st_d[ST_IRQ] = 1'b0;
    end
    if (ev_err) st_d[ST_ERR] = 1'b1;
    if (ev_irq) st_d[ST_IRQ] = 1'b1;
    st_en = st_we || ev_err || ev_irq;

    ptr_d = ptr_q;
    for (int l = 0; l < LANES; l++) begin
      if (ptr_be[l]) ptr_d[l*8 +: 8] = ptr_wdata[l*8 +: 8];
    end
    ptr_d[1:0] = 2'b00;
    ptr_en     = |ptr_be;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      st_q  <= '0;
      ptr_q <= '0;
    end else begin
      if (cmd_we) cmd_q <= cmd_d;
      if (st_en)  st_q  <= st_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  // R6: an event pulse leaves the flag set
  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq |=> st_q[ST_IRQ]);
  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> st_q[ST_ERR]);
  // R6: write-one clears when no event competes
  assert_irq_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && byte_wdata[ST_IRQ] && !ev_irq) |=> !st_q[ST_IRQ]);
  // R7: reserved status bits stay zero
  assert_st_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[0] == 1'b0 && st_q[3] == 1'b0 && st_q[4] == 1'b0 && st_q[7] == 1'b0));

endmodule

// File: rtl/busmaster_regwin.sv
module busmaster_regwin
  import bmw_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        io_addr,
  input  logic [1:0]               io_size,
  input  logic                     io_rd,
  input  logic                     io_wr,
  input  logic [DATA_W-1:0]        io_wdata,
  output logic [DATA_W-1:0]        io_rdata,
  input  logic [NUM_CH-1:0]        ev_irq,
  input  logic [NUM_CH-1:0]        ev_err,
  output logic [NUM_CH-1:0]        dma_start,
  output logic [NUM_CH-1:0]        dma_dir,
  output logic [NUM_CH*DATA_W-1:0] dma_ptr
);

  localparam int CH_W = ADDR_W - 3;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_CH-1:0]       cmd_we;
  logic [NUM_CH-1:0]       st_we;
  logic [NUM_CH*LANES-1:0] ptr_be;
  logic [DATA_W-1:0]       ptr_wdata;

  bmw_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr      (io_addr),
    .size      (io_size),
    .wr        (io_wr),
    .wdata     (io_wdata),
    .cmd_we    (cmd_we),
    .st_we     (st_we),
    .ptr_be    (ptr_be),
    .ptr_wdata (ptr_wdata)
  );

  logic [7:0]        cmd_arr [NUM_CH];
  logic [7:0]        st_arr  [NUM_CH];
  logic [DATA_W-1:0] ptr_arr [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bmw_channel u_ch (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .cmd_we     (cmd_we[c]),
      .st_we      (st_we[c]),
      .ptr_be     (ptr_be[c*LANES +: LANES]),
      .byte_wdata (io_wdata[7:0]),
      .ptr_wdata  (ptr_wdata),
      .ev_irq     (ev_irq[c]),
      .ev_err     (ev_err[c]),
      .cmd_q      (cmd_arr[c]),
      .st_q       (st_arr[c]),
      .ptr_q      (ptr_arr[c])
    );
    assign dma_start[c]                = cmd_arr[c][CMD_START];
    assign dma_dir[c]                  = cmd_arr[c][CMD_DIR];
    assign dma_ptr[c*DATA_W +: DATA_W] = ptr_arr[c];
  end

  // read mux
  logic [CH_W-1:0]   rd_ch;
  logic [DATA_W-1:0] rd_mask;
  logic [1:0]        rd_off;
  logic [7:0]        sel_cmd;
  logic [7:0]        sel_st;
  logic [DATA_W-1:0] sel_ptr;

  always_comb begin
    rd_ch   = io_addr[ADDR_W-1:3];
    rd_mask = width_mask(io_size);
    rd_off  = lane_off(io_size, io_addr[1:0]);
    sel_cmd = 8'h00;
    sel_st  = 8'h00;
    sel_ptr = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_ch == c[CH_W-1:0]) begin
        sel_cmd = cmd_arr[c];
        sel_st  = st_arr[c];
        sel_ptr = ptr_arr[c];
      end
    end

    io_rdata = '0;
    if (io_rd) begin
      if (io_addr[2]) begin
        io_rdata = (sel_ptr >> {rd_off, 3'b000}) & rd_mask;
      end else if (io_size != SZ_BYTE) begin
        io_rdata = rd_mask;
      end else begin
        case (io_addr[1:0])
          OFF_CMD: io_rdata = {24'h0, sel_cmd};
          OFF_ST:  io_rdata = {24'h0, sel_st};
          default: io_rdata = 32'h0000_00FF;
        endcase
      end
    end
  end

  // R10: idle bus reads zero
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !io_rd |-> (io_rdata == '0));
  // R3: four-byte read of the command/status area is all ones
  assert_wide_ones_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && !io_addr[2] && io_size[1]) |-> (io_rdata == 32'hFFFF_FFFF));
  // R4: wide writes leave the command outputs unchanged
  assert_wide_wr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && !io_addr[2] && io_size != SZ_BYTE) |=> ($stable(dma_start) && $stable(dma_dir)));
  // R9: pointer low bits read zero
  assert_ptr_low_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && io_addr[2] && io_addr[1:0] == 2'b00) |-> (io_rdata[1:0] == 2'b00));

endmodule

// File: tb/busmaster_regwin_bench.sv
`timescale 1ns/1ps
module busmaster_regwin_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  io_addr;
  logic [1:0]  io_size;
  logic        io_rd;
  logic        io_wr;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;
  logic [1:0]  ev_irq;
  logic [1:0]  ev_err;
  logic [1:0]  dma_start;
  logic [1:0]  dma_dir;
  logic [63:0] dma_ptr;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_cmd [2];
  logic [7:0]  m_st  [2];
  logic [31:0] m_ptr [2];

  always #2 clk = ~clk;

  busmaster_regwin u_busmaster_regwin (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ev_irq(ev_irq), .ev_err(ev_err), .dma_start(dma_start),
    .dma_dir(dma_dir), .dma_ptr(dma_ptr)
  );

  function automatic logic [1:0] eoff(input logic [1:0] s, input logic [1:0] lo);
    if (s == 2'd0) return lo;
    if (s == 2'd1) return {lo[1], 1'b0};
    return 2'd0;
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] s);
    if (s == 2'd0) return 32'hFF;
    if (s == 2'd1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] s);
    logic [31:0] sh;
    if (a[2]) begin
      sh = m_ptr[a[3]] >> (8 * eoff(s, a[1:0]));
      return sh & wmask(s);
    end
    if (s != 2'd0) return wmask(s);
    if (a[1:0] == 2'd0) return {24'h0, m_cmd[a[3]]};
    if (a[1:0] == 2'd2) return {24'h0, m_st[a[3]]};
    return 32'hFF;
  endfunction

  function automatic string tag_of(input logic [3:0] a, input logic [1:0] s);
    if (a[2]) return "R8";
    if (s != 2'd0) return "R3";
    return "R2";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_update(input logic rd, input logic wr, input logic [3:0] a,
                              input logic [1:0] s, input logic [31:0] wd,
                              input logic [1:0] ei, input logic [1:0] ee);
    logic [31:0] al;
    logic [1:0]  o;
    if (wr) begin
      if (!a[2]) begin
        if (s == 2'd0 && a[1:0] == 2'd0) m_cmd[a[3]] = wd[7:0];
        if (s == 2'd0 && a[1:0] == 2'd2) begin
          m_st[a[3]][5] = wd[5];
          m_st[a[3]][6] = wd[6];
          if (wd[1]) m_st[a[3]][1] = 1'b0;
          if (wd[2]) m_st[a[3]][2] = 1'b0;
        end
      end else begin
        o  = eoff(s, a[1:0]);
        al = wd << (8 * o);
        for (int l = 0; l < 4; l++) begin
          if ((wmask(s) >> (8 * l)) != 0 || l >= o) begin
            if (l >= o && l < o + ((s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4))
              m_ptr[a[3]][l*8 +: 8] = al[l*8 +: 8];
          end
        end
        m_ptr[a[3]][1:0] = 2'b00;
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (ee[c]) m_st[c][1] = 1'b1;
      if (ei[c]) m_st[c][2] = 1'b1;
    end
    if (rd) begin end
  endtask

  // one bus cycle: drive, check, clock, update model
  task automatic cyc(input logic rd, input logic wr, input logic [3:0] a,
                     input logic [1:0] s, input logic [31:0] wd,
                     input logic [1:0] ei, input logic [1:0] ee, input string req);
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a; io_size = s; io_wdata = wd;
    ev_irq = ei; ev_err = ee;
    #1;
    if (rd) chk(req, io_rdata, exp_read(a, s));
    else    chk("R10", io_rdata, 32'h0);
    for (int c = 0; c < 2; c++) begin
      chk("R5", {30'h0, dma_dir[c], dma_start[c]}, {30'h0, m_cmd[c][3], m_cmd[c][0]});
      chk("R8", dma_ptr[c*32 +: 32], m_ptr[c]);
    end
    @(posedge clk);
    model_update(rd, wr, a, s, wd, ei, ee);
  endtask

  task automatic rd_(input logic [3:0] a, input logic [1:0] s, input string req);
    cyc(1'b1, 1'b0, a, s, 32'h0, 2'b00, 2'b00, req);
  endtask

  task automatic wr_(input logic [3:0] a, input logic [1:0] s, input logic [31:0] wd);
    cyc(1'b0, 1'b1, a, s, wd, 2'b00, 2'b00, "R10");
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; io_rd = 0; io_wr = 0; io_addr = 0; io_size = 0;
    io_wdata = 0; ev_irq = 0; ev_err = 0;
    for (int c = 0; c < 2; c++) begin m_cmd[c] = 0; m_st[c] = 0; m_ptr[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: reset state
    rd_(4'h0, 2'd0, "R10"); rd_(4'h2, 2'd0, "R10"); rd_(4'h4, 2'd2, "R10");
    rd_(4'h8, 2'd0, "R10"); rd_(4'hA, 2'd0, "R10"); rd_(4'hC, 2'd2, "R10");

    // R5: command byte and outputs
    wr_(4'h8, 2'd0, 32'h0000_0009);
    rd_(4'h8, 2'd0, "R5");
    chk("R5", {30'h0, dma_dir[1], dma_start[1]}, 32'h3);
    // R4: wide writes ignored
    wr_(4'h8, 2'd2, 32'hFFFF_FFF0);
    wr_(4'hA, 2'd1, 32'h0000_0066);
    rd_(4'h8, 2'd0, "R4"); rd_(4'hA, 2'd0, "R4");
    // R3: wide reads all ones
    rd_(4'h0, 2'd1, "R3"); rd_(4'h8, 2'd2, "R3"); rd_(4'h2, 2'd3, "R3");
    // R2: unused bytes
    wr_(4'h1, 2'd0, 32'hAB); wr_(4'h3, 2'd0, 32'hFF);
    rd_(4'h1, 2'd0, "R2"); rd_(4'h3, 2'd0, "R2");
    rd_(4'h0, 2'd0, "R2"); rd_(4'h2, 2'd0, "R2");
    // R6: events, W1C, set-wins
    cyc(1'b0, 1'b0, 4'h0, 2'd0, 0, 2'b01, 2'b01, "R10");
    rd_(4'h2, 2'd0, "R6");
    wr_(4'h2, 2'd0, 32'h00); rd_(4'h2, 2'd0, "R6");
    wr_(4'h2, 2'd0, 32'h04); rd_(4'h2, 2'd0, "R6");
    cyc(1'b0, 1'b1, 4'h2, 2'd0, 32'h06, 2'b01, 2'b00, "R10");
    rd_(4'h2, 2'd0, "R6");
    // R7: capability bits and reserved bits
    wr_(4'hA, 2'd0, 32'hF9); rd_(4'hA, 2'd0, "R7");
    // R8/R9/R1: pointer lanes
    wr_(4'h4, 2'd2, 32'hDEAD_BEEF);
    rd_(4'h4, 2'd2, "R9"); rd_(4'h6, 2'd1, "R8"); rd_(4'h5, 2'd0, "R8");
    rd_(4'hC, 2'd2, "R1");
    wr_(4'hE, 2'd1, 32'h1234); wr_(4'hD, 2'd0, 32'h56);
    rd_(4'hC, 2'd2, "R8"); rd_(4'h4, 2'd2, "R1");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a; logic [1:0] s; logic [31:0] wd; int op;
      a  = 4'($urandom);
      s  = 2'($urandom);
      wd = $urandom;
      op = $urandom % 3;
      cyc(op == 0, op == 1, a, s, wd,
          (($urandom % 8) == 0) ? 2'($urandom) : 2'b00,
          (($urandom % 8) == 0) ? 2'($urandom) : 2'b00,
          tag_of(a, s));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule